// File: doc/BRIEF.md
# Shared Bus Arbiter with Retry

This block decides who drives a shared external bus: the chip's own bus master, or a single external master. The bus pins are all active low. A mode input picks where arbitration happens. With the on-chip arbiter selected, the block takes the external master's request and busy lines and answers with a grant. When nothing is pending, the bus parks on the chip, so the chip can start a transfer without a grant handshake. With an outside arbiter selected, the block raises the chip's own request. It waits until it sees a grant while the bus is not busy, and only then asserts busy and takes the bus.

Two more pins settle conflicts. Suppose the external master holds the bus and the chip needs it. The block then drives retry low for exactly one clock, which pushes the external master off, and the chip takes the bus. A retry arriving from a slave while the chip owns the bus makes the block drop busy and compete for the bus again. Burst inhibit is driven low whenever the external master runs a burst into the chip's internal address window.

The chip side uses plain control pins, not a data stream, so no back-pressure rules apply. `chip_req` is held high until the transfer ends. `chip_owns` reports ownership. `chip_done` is pulsed high for one cycle to end the tenure.

Top module: `shared_bus_arbiter`

## Requirements
- R1: During and after reset, every active-low output (`bus_busy_n_o`, `xm_grant_n`, `chip_req_n`, `retry_n_o`, `burst_inh_n`) reads 1, and `chip_owns` reads 0.
- R2: In on-chip mode with the bus idle, a `chip_req` sampled high makes `bus_busy_n_o` go to 0 and `chip_owns` go to 1 one cycle later, while `xm_grant_n` stays 1 (parking, no grant).
- R3: In on-chip mode with the bus idle, `xm_req_n` sampled 0 with `chip_req` low drives `xm_grant_n` to 0 one cycle later. If both requests are sampled in the same cycle, the chip wins and `xm_grant_n` stays 1.
- R4: While the grant is out, sampling `bus_busy_n_i` = 0 ends the grant (`xm_grant_n` = 1) and the external master becomes owner. Sampling `bus_busy_n_i` = 1 during its tenure returns the bus to idle. If `xm_req_n` rises before busy is ever seen, the grant is withdrawn.
- R5: If the external master owns the bus and `chip_req` is sampled high, `retry_n_o` is 0 for exactly one cycle. The next cycle has `retry_n_o` = 1 and `bus_busy_n_o` = 0.
- R6: In outside-arbiter mode with `park` = 0, a `chip_req` from idle drives `chip_req_n` to 0. It stays 0 until a cycle samples `grant_n_i` = 0 and `bus_busy_n_i` = 1. One cycle after that, `chip_req_n` = 1 and `bus_busy_n_o` = 0. A grant seen while the bus is busy is not taken.
- R7: In outside-arbiter mode with `park` = 1, a `chip_req` from idle takes the bus one cycle later, and `chip_req_n` stays 1.
- R8: A `chip_done` sampled high while the chip owns the bus releases it one cycle later (`bus_busy_n_o` = 1, `chip_owns` = 0).
- R9: A `slave_retry_n` sampled 0 while the chip owns the bus releases busy one cycle later, and it takes priority over `chip_done`. If `chip_req` is still high, the block competes again from idle on the following cycle.
- R10: `burst_inh_n` is combinationally 0 exactly when all of these hold: `xm_burst` = 1, `xm_addr` lies in [`INT_BASE`, `INT_BASE` + 2^`INT_SPAN_LOG2`), `bus_busy_n_i` = 0, and the chip does not own the bus.
- R11: `internal_arb` is only acted on when the bus is idle. A change during chip ownership leaves the outputs unchanged. In outside-arbiter mode, `xm_req_n` has no effect and `xm_grant_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| internal_arb | input | 1 | 1 selects the on-chip arbiter, 0 an outside arbiter |
| park | input | 1 | Outside-arbiter mode: the bus is parked on the chip |
| chip_req | input | 1 | Chip side needs the external bus; held until done |
| chip_done | input | 1 | One-cycle pulse that ends the chip's tenure |
| chip_owns | output | 1 | Chip currently owns the bus |
| xm_req_n | input | 1 | External master request, active low |
| xm_grant_n | output | 1 | Grant to the external master, active low |
| bus_busy_n_i | input | 1 | Bus busy as seen on the bus, active low |
| bus_busy_n_o | output | 1 | Busy driven by the chip, active low |
| chip_req_n | output | 1 | Chip's request to an outside arbiter, active low |
| grant_n_i | input | 1 | Grant from an outside arbiter, active low |
| slave_retry_n | input | 1 | Retry from the addressed slave, active low |
| retry_n_o | output | 1 | Retry driven to evict the external master, active low |
| xm_burst | input | 1 | External master access is a burst |
| xm_addr | input | ADDR_W | External master access address |
| burst_inh_n | output | 1 | Burst inhibit, active low |

## Verification
The hardest situation to reach is the eviction. The external master must first be granted the bus and must then drive busy, and only after that can a chip request arrive; that request must trigger one retry cycle and then a chip takeover. The stimulus follows that order: grant, busy, then the chip request. A second hard case is slave retry arriving in the same cycle as done, with the request still held. The bench raises both together and keeps the outside grant asserted, so the re-request and the retake can be seen on the next two cycles. A reference model tracks ownership every clock and compares all six outputs.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic [2:0] {
    SBA_IDLE  = 3'd0,
    SBA_CHIP  = 3'd1,
    SBA_REQ   = 3'd2,
    SBA_XGNT  = 3'd3,
    SBA_XBUSY = 3'd4,
    SBA_EVICT = 3'd5
  } sba_state_e;
endpackage

// File: rtl/sba_window_hit.sv
module sba_window_hit #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] INT_BASE = '0,
  parameter int INT_SPAN_LOG2 = 20
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] MASK = ~((ONE << INT_SPAN_LOG2) - ONE);

  assign hit = ((addr ^ INT_BASE) & MASK) == '0;
endmodule

// File: rtl/sba_owner_fsm.sv
module sba_owner_fsm
  import sba_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       internal_arb,
  input  logic       park,
  input  logic       chip_req,
  input  logic       chip_done,
  input  logic       xm_req_n,
  input  logic       bus_busy_n_i,
  input  logic       grant_n_i,
  input  logic       slave_retry_n,
  output sba_state_e nxt
);
  sba_state_e cur;

  always_comb begin
    nxt = cur;
    unique case (cur)
      SBA_IDLE: begin
        if (internal_arb) begin
          if (chip_req)       nxt = SBA_CHIP;
          else if (!xm_req_n) nxt = SBA_XGNT;
        end else if (chip_req) begin
          nxt = park ? SBA_CHIP : SBA_REQ;
        end
      end
      SBA_CHIP:
        if (!slave_retry_n || chip_done) nxt = SBA_IDLE;
      SBA_REQ: begin
        if (!chip_req)                       nxt = SBA_IDLE;
        else if (!grant_n_i && bus_busy_n_i) nxt = SBA_CHIP;
      end
      SBA_XGNT: begin
        if (!bus_busy_n_i)  nxt = SBA_XBUSY;
        else if (xm_req_n)  nxt = SBA_IDLE;
      end
      SBA_XBUSY: begin
        if (bus_busy_n_i)   nxt = SBA_IDLE;
        else if (chip_req)  nxt = SBA_EVICT;
      end
      SBA_EVICT:
        nxt = chip_req ? SBA_CHIP : SBA_IDLE;
      default: nxt = SBA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cur <= SBA_IDLE;
    else        cur <= nxt;
endmodule

// File: rtl/sba_pin_drive.sv
module sba_pin_drive
  import sba_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sba_state_e nxt,
  input  logic       xm_burst,
  input  logic       win_hit,
  input  logic       bus_busy_n_i,
  output logic       chip_owns,
  output logic       xm_grant_n,
  output logic       bus_busy_n_o,
  output logic       chip_req_n,
  output logic       retry_n_o,
  output logic       burst_inh_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_owns    <= 1'b0;
      xm_grant_n   <= 1'b1;
      bus_busy_n_o <= 1'b1;
      chip_req_n   <= 1'b1;
      retry_n_o    <= 1'b1;
    end else begin
      chip_owns    <= (nxt == SBA_CHIP);
      bus_busy_n_o <= (nxt != SBA_CHIP);
      xm_grant_n   <= (nxt != SBA_XGNT);
      chip_req_n   <= (nxt != SBA_REQ);
      retry_n_o    <= (nxt != SBA_EVICT);
    end
  end

  assign burst_inh_n = !(xm_burst && win_hit && !bus_busy_n_i && !chip_owns);
endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter
  import sba_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] INT_BASE = 32'h0010_0000,
  parameter int INT_SPAN_LOG2 = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              internal_arb,
  input  logic              park,
  input  logic              chip_req,
  input  logic              chip_done,
  output logic              chip_owns,
  input  logic              xm_req_n,
  output logic              xm_grant_n,
  input  logic              bus_busy_n_i,
  output logic              bus_busy_n_o,
  output logic              chip_req_n,
  input  logic              grant_n_i,
  input  logic              slave_retry_n,
  output logic              retry_n_o,
  input  logic              xm_burst,
  input  logic [ADDR_W-1:0] xm_addr,
  output logic              burst_inh_n
);
  sba_state_e nxt;
  logic       win_hit;

  sba_owner_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .internal_arb(internal_arb), .park(park),
    .chip_req(chip_req), .chip_done(chip_done), .xm_req_n(xm_req_n),
    .bus_busy_n_i(bus_busy_n_i), .grant_n_i(grant_n_i),
    .slave_retry_n(slave_retry_n), .nxt(nxt)
  );

  sba_window_hit #(
    .ADDR_W(ADDR_W), .INT_BASE(INT_BASE), .INT_SPAN_LOG2(INT_SPAN_LOG2)
  ) u_win (
    .addr(xm_addr), .hit(win_hit)
  );

  sba_pin_drive u_pins (
    .clk(clk), .rst_n(rst_n), .nxt(nxt), .xm_burst(xm_burst),
    .win_hit(win_hit), .bus_busy_n_i(bus_busy_n_i),
    .chip_owns(chip_owns), .xm_grant_n(xm_grant_n),
    .bus_busy_n_o(bus_busy_n_o), .chip_req_n(chip_req_n),
    .retry_n_o(retry_n_o), .burst_inh_n(burst_inh_n)
  );
endmodule

// File: rtl/sba_checker.sv
module sba_checker (
  input logic clk,
  input logic rst_n,
  input logic chip_req,
  input logic chip_done,
  input logic chip_owns,
  input logic xm_grant_n,
  input logic bus_busy_n_i,
  input logic bus_busy_n_o,
  input logic chip_req_n,
  input logic grant_n_i,
  input logic slave_retry_n,
  input logic retry_n_o,
  input logic xm_burst,
  input logic burst_inh_n
);
  assert_one_driver_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!xm_grant_n, !chip_req_n, !retry_n_o, !bus_busy_n_o}));

  assert_evict_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!retry_n_o && chip_req) |=> (retry_n_o && !bus_busy_n_o));

  assert_qual_grant_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_req_n && chip_req && !grant_n_i && bus_busy_n_i) |=> (chip_req_n && !bus_busy_n_o));

  assert_busy_grant_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_req_n && chip_req && !bus_busy_n_i) |=> !chip_req_n);

  assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_owns && chip_done) |=> (bus_busy_n_o && !chip_owns));

  assert_retry_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_owns && !slave_retry_n) |=> bus_busy_n_o);

  assert_inhibit_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_inh_n |-> (xm_burst && !bus_busy_n_i && !chip_owns));
endmodule

bind shared_bus_arbiter sba_checker u_sba_checker (
  .clk(clk), .rst_n(rst_n), .chip_req(chip_req), .chip_done(chip_done),
  .chip_owns(chip_owns), .xm_grant_n(xm_grant_n), .bus_busy_n_i(bus_busy_n_i),
  .bus_busy_n_o(bus_busy_n_o), .chip_req_n(chip_req_n), .grant_n_i(grant_n_i),
  .slave_retry_n(slave_retry_n), .retry_n_o(retry_n_o), .xm_burst(xm_burst),
  .burst_inh_n(burst_inh_n)
);

// File: tb/shared_bus_arbiter_bench.sv
`timescale 1ns/1ps
module shared_bus_arbiter_bench;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam longint      SPAN = 64'd1 << 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic internal_arb = 1'b1, park = 1'b0, chip_req = 1'b0, chip_done = 1'b0;
  logic xm_req_n = 1'b1, bus_busy_n_i = 1'b1, grant_n_i = 1'b1, slave_retry_n = 1'b1;
  logic xm_burst = 1'b0;
  logic [31:0] xm_addr = '0;
  logic chip_owns, xm_grant_n, bus_busy_n_o, chip_req_n, retry_n_o, burst_inh_n;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  shared_bus_arbiter u_shared_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .internal_arb(internal_arb), .park(park),
    .chip_req(chip_req), .chip_done(chip_done), .chip_owns(chip_owns),
    .xm_req_n(xm_req_n), .xm_grant_n(xm_grant_n), .bus_busy_n_i(bus_busy_n_i),
    .bus_busy_n_o(bus_busy_n_o), .chip_req_n(chip_req_n), .grant_n_i(grant_n_i),
    .slave_retry_n(slave_retry_n), .retry_n_o(retry_n_o), .xm_burst(xm_burst),
    .xm_addr(xm_addr), .burst_inh_n(burst_inh_n)
  );

  // Reference model: ownership flags, updated behaviourally each clock.
  bit m_chip, m_gnt, m_ext, m_ask, m_kick;
  always @(posedge clk or negedge rst_n) begin
    bit c, g, e, a, k;
    if (!rst_n) begin
      m_chip = 0; m_gnt = 0; m_ext = 0; m_ask = 0; m_kick = 0;
    end else begin
      c = m_chip; g = m_gnt; e = m_ext; a = m_ask; k = m_kick;
      if (!(c || g || e || a || k)) begin
        if (internal_arb) begin
          if (chip_req) m_chip = 1;
          else if (!xm_req_n) m_gnt = 1;
        end else if (chip_req) begin
          if (park) m_chip = 1; else m_ask = 1;
        end
      end else if (c) begin
        if (!slave_retry_n || chip_done) m_chip = 0;
      end else if (a) begin
        if (!chip_req) m_ask = 0;
        else if (!grant_n_i && bus_busy_n_i) begin m_ask = 0; m_chip = 1; end
      end else if (g) begin
        if (!bus_busy_n_i) begin m_gnt = 0; m_ext = 1; end
        else if (xm_req_n) m_gnt = 0;
      end else if (e) begin
        if (bus_busy_n_i) m_ext = 0;
        else if (chip_req) begin m_ext = 0; m_kick = 1; end
      end else begin
        m_kick = 0;
        m_chip = chip_req;
      end
    end
  end

  function automatic bit exp_inh_n();
    bit hit = ({32'd0, xm_addr} >= {32'd0, BASE}) && ({32'd0, xm_addr} < {32'd0, BASE} + SPAN);
    return !(xm_burst && hit && !bus_busy_n_i && !m_chip);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2 busy out", bus_busy_n_o, !m_chip);
    chk("R8 chip_owns", chip_owns, m_chip);
    chk("R3 grant out", xm_grant_n, !m_gnt);
    chk("R6 request out", chip_req_n, !m_ask);
    chk("R5 retry out", retry_n_o, !m_kick);
    chk("R10 burst inhibit", burst_inh_n, exp_inh_n());
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    // R1 reset state
    chk("R1 busy", bus_busy_n_o, 1'b1); chk("R1 grant", xm_grant_n, 1'b1);
    chk("R1 req", chip_req_n, 1'b1);    chk("R1 retry", retry_n_o, 1'b1);
    chk("R1 inhibit", burst_inh_n, 1'b1); chk("R1 owns", chip_owns, 1'b0);
    rst_n = 1'b1; cyc(2);

    // R2 parked chip access, then R8 done
    chip_req = 1; cyc();
    chk("R2 busy low", bus_busy_n_o, 1'b0); chk("R2 no grant", xm_grant_n, 1'b1);
    cyc();
    chip_req = 0; chip_done = 1; cyc();
    chk("R8 released", bus_busy_n_o, 1'b1);
    chip_done = 0; cyc();

    // R3/R4 grant and external tenure, R10 inhibit, R5 eviction
    xm_req_n = 0; cyc();
    chk("R3 grant low", xm_grant_n, 1'b0);
    bus_busy_n_i = 0; cyc();
    chk("R4 grant ends on busy", xm_grant_n, 1'b1);
    xm_burst = 1; xm_addr = 32'h0012_3456; #1;
    chk("R10 inhibit in window", burst_inh_n, 1'b0);
    xm_addr = 32'h0020_0000; #1;
    chk("R10 no inhibit above", burst_inh_n, 1'b1);
    xm_addr = 32'h000F_FFFF; #1;
    chk("R10 no inhibit below", burst_inh_n, 1'b1);
    xm_addr = 32'h0010_0000;
    chip_req = 1; cyc();
    chk("R5 retry low", retry_n_o, 1'b0);
    cyc();
    chk("R5 retry one cycle", retry_n_o, 1'b1); chk("R5 chip busy", bus_busy_n_o, 1'b0);
    chk("R10 no inhibit when chip owns", burst_inh_n, 1'b1);
    xm_burst = 0; chip_req = 0; chip_done = 1; xm_req_n = 1; bus_busy_n_i = 1; cyc();
    chip_done = 0; cyc();

    // R4 grant withdrawn
    xm_req_n = 0; cyc();
    xm_req_n = 1; cyc();
    chk("R4 grant withdrawn", xm_grant_n, 1'b1);

    // R3 simultaneous requests: chip wins
    xm_req_n = 0; chip_req = 1; cyc();
    chk("R3 chip wins", bus_busy_n_o, 1'b0); chk("R3 no grant", xm_grant_n, 1'b1);
    chip_req = 0; chip_done = 1; xm_req_n = 1; cyc();
    chip_done = 0; cyc();

    // R6 outside arbiter, R9 slave retry
    internal_arb = 0; chip_req = 1; grant_n_i = 0; bus_busy_n_i = 0; cyc(2);
    chk("R6 busy grant not taken", chip_req_n, 1'b0);
    chk("R6 no busy yet", bus_busy_n_o, 1'b1);
    bus_busy_n_i = 1; cyc();
    chk("R6 taken", bus_busy_n_o, 1'b0); chk("R6 request dropped", chip_req_n, 1'b1);
    slave_retry_n = 0; chip_done = 1; cyc();
    chk("R9 busy released", bus_busy_n_o, 1'b1);
    slave_retry_n = 1; chip_done = 0; cyc();
    chk("R9 re-request", chip_req_n, 1'b0);
    cyc();
    chk("R9 retaken", bus_busy_n_o, 1'b0);
    chip_req = 0; chip_done = 1; grant_n_i = 1; cyc();
    chip_done = 0; cyc();

    // R7 parked in outside-arbiter mode
    park = 1; chip_req = 1; cyc();
    chk("R7 owns directly", bus_busy_n_o, 1'b0); chk("R7 no request", chip_req_n, 1'b1);

    // R11 mode change during ownership, ext request ignored in outside mode
    internal_arb = 1; xm_req_n = 0; cyc();
    chk("R11 still owns", chip_owns, 1'b1); chk("R11 no grant", xm_grant_n, 1'b1);
    chip_req = 0; chip_done = 1; internal_arb = 0; cyc();
    chip_done = 0; cyc(2);
    chk("R11 ext request ignored", xm_grant_n, 1'b1);
    xm_req_n = 1; park = 0;

    // R10 inhibit in outside mode while external master busy
    bus_busy_n_i = 0; xm_burst = 1; xm_addr = 32'h001F_FFFF; #1;
    chk("R10 inhibit top of window", burst_inh_n, 1'b0);
    xm_burst = 0; #1;
    chk("R10 single beat no inhibit", burst_inh_n, 1'b1);
    bus_busy_n_i = 1; cyc(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule